// File: doc/BRIEF.md
# USB Suspend and Clock-Request Controller

This block watches the bus of a USB device for idle periods and runs the device's suspend state and its request for the main clock. A bus-activity indication, derived elsewhere from the line state, resets an idle counter. A 1 ms timebase tick advances that counter while the bus stays quiet. Once the idle time exceeds a first limit, the block raises a suspend flag and pulses an interrupt, so that software can get ready for low power. If the bus stays quiet for a further interval, the block drops its need-clock output, and the main clock may then be stopped.

Bus activity works as a host-initiated wakeup. It clears the suspend flag and raises need-clock through a purely combinational path, so the wake does not wait for a clock edge. The registered state is cleared on the next edge once the clock runs again. Software can also start a remote wakeup. While the device is suspended and its clocks are enabled, a request from software clears suspend and raises a remote-wakeup request towards the upstream signalling logic. That request holds until the bus shows activity.

Top module: `usb_susp_ctrl`

## Requirements
- R1: After reset, suspend_o is 0, need_clk_o is 1, susp_irq_o is 0 and rwake_req_o is 0.
- R2: With bus_act_i low, suspend_o rises on the clock edge after the edge that samples the (SUSP_MS+1)-th tick_1ms_i pulse since the last activity or accepted wake.
- R3: susp_irq_o is high for exactly one cycle, in the cycle in which the registered suspend state first becomes 1. It does not pulse again until suspend has been cleared.
- R4: need_clk_o falls on the clock edge after the edge that samples the (SUSP_MS+1+CLK_OFF_MS)-th idle tick. need_clk_o is never low while suspend is inactive.
- R5: While bus_act_i is 1, suspend_o is 0 and need_clk_o is 1 in the same cycle, without a clock edge. The next edge clears the registered suspend and clock-release state.
- R6: When sw_wake_i is sampled high while the registered suspend state is 1, clk_en_i is 1 and bus_act_i is 0, then on that edge suspend clears, the idle count returns to zero and rwake_req_o becomes 1.
- R7: sw_wake_i has no effect if suspend is inactive or clk_en_i is 0. After an accepted request, rwake_req_o stays 1 until an edge samples bus_act_i high, and it clears on that edge.
- R8: Every edge that samples bus_act_i high returns the idle count to zero, so idle ticks before the activity do not count towards either timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_act_i | input | 1 | Bus activity seen on the line |
| tick_1ms_i | input | 1 | One-cycle pulse every millisecond |
| sw_wake_i | input | 1 | Software request to clear suspend and wake the host |
| clk_en_i | input | 1 | Device clocks are enabled |
| suspend_o | output | 1 | Suspend flag |
| susp_irq_o | output | 1 | One-cycle pulse on entry to suspend |
| need_clk_o | output | 1 | Main clock is required |
| rwake_req_o | output | 1 | Request for remote-wakeup signalling upstream |

## Verification
The bench builds the block with its default limits of 3 ms to suspend and 2 ms more to clock release. It drives a tick every four cycles, so a full idle run to clock release takes only a few dozen cycles. With these values the bench can reach both thresholds, activity that lands just short of a threshold, activity while the clock is released, and wake requests both before and after the block enters suspend. A final pseudo-random phase mixes activity, ticks, wake requests and clock-enable changes, and the behavioural model is compared against the outputs on every cycle.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;
  typedef struct packed {
    logic susp;
    logic clk_off;
  } susp_state_t;
endpackage

// File: rtl/usb_idle_cnt.sv
module usb_idle_cnt #(
  parameter int unsigned SUSP_LIM = 4,
  parameter int unsigned OFF_LIM  = 6,
  localparam int unsigned CNT_W   = $clog2(OFF_LIM + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic susp_hit_o,
  output logic off_hit_o
);
  localparam logic [CNT_W-1:0] OFF_V  = CNT_W'(OFF_LIM);
  localparam logic [CNT_W-1:0] SUSP_V = CNT_W'(SUSP_LIM);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (tick_i && cnt_q < OFF_V) cnt_q <= cnt_q + 1'b1;
  end

  assign susp_hit_o = (cnt_q >= SUSP_V);
  assign off_hit_o  = (cnt_q >= OFF_V);
endmodule

// File: rtl/usb_susp_state.sv
module usb_susp_state
  import usb_susp_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        susp_hit_i,
  input  logic        off_hit_i,
  output susp_state_t st_o,
  output logic        irq_o
);
  susp_state_t st_q;
  logic        irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      irq_q <= 1'b0;
    end else if (clr_i) begin
      st_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= susp_hit_i && !st_q.susp;
      if (susp_hit_i) st_q.susp    <= 1'b1;
      if (off_hit_i)  st_q.clk_off <= 1'b1;
    end
  end

  assign st_o  = st_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/usb_rwake_ctrl.sv
module usb_rwake_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic accept_i,
  output logic rwake_o
);
  logic rw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rw_q <= 1'b0;
    else if (act_i)    rw_q <= 1'b0;
    else if (accept_i) rw_q <= 1'b1;
  end

  assign rwake_o = rw_q;
endmodule

// File: rtl/usb_susp_ctrl.sv
module usb_susp_ctrl
  import usb_susp_pkg::*;
#(
  parameter int unsigned SUSP_MS    = 3,
  parameter int unsigned CLK_OFF_MS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_act_i,
  input  logic tick_1ms_i,
  input  logic sw_wake_i,
  input  logic clk_en_i,
  output logic suspend_o,
  output logic susp_irq_o,
  output logic need_clk_o,
  output logic rwake_req_o
);
  // suspend needs strictly more than SUSP_MS idle ticks
  localparam int unsigned SUSP_LIM = SUSP_MS + 1;
  localparam int unsigned OFF_LIM  = SUSP_LIM + CLK_OFF_MS;

  susp_state_t st;
  logic susp_hit, off_hit, accept, clr;

  assign accept = sw_wake_i && clk_en_i && st.susp;
  assign clr    = bus_act_i || accept;

  usb_idle_cnt #(.SUSP_LIM(SUSP_LIM), .OFF_LIM(OFF_LIM)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .tick_i     (tick_1ms_i),
    .susp_hit_o (susp_hit),
    .off_hit_o  (off_hit)
  );

  usb_susp_state i_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .susp_hit_i (susp_hit),
    .off_hit_i  (off_hit),
    .st_o       (st),
    .irq_o      (susp_irq_o)
  );

  usb_rwake_ctrl i_rwake (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .act_i    (bus_act_i),
    .accept_i (accept),
    .rwake_o  (rwake_req_o)
  );

  // wake path is combinational: works with the main clock stopped
  assign suspend_o  = st.susp && !bus_act_i;
  assign need_clk_o = !st.clk_off || bus_act_i;
endmodule

// File: rtl/usb_susp_ctrl_chk.sv
module usb_susp_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_act_i,
  input logic sw_wake_i,
  input logic clk_en_i,
  input logic suspend_o,
  input logic susp_irq_o,
  input logic need_clk_o,
  input logic rwake_req_o
);
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_irq_o |=> !susp_irq_o); // R3
  AST_IRQ_IN_SUSPEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_irq_o |-> (suspend_o || bus_act_i)); // R3
  AST_CLK_OFF_IN_SUSPEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !need_clk_o |-> suspend_o); // R4
  AST_ACT_WAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_act_i |-> (!suspend_o && need_clk_o)); // R5
  AST_ACT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_act_i |=> (!rwake_req_o && need_clk_o)); // R5
  AST_RWAKE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_wake_i && clk_en_i && suspend_o) |=> (rwake_req_o && !suspend_o)); // R6
  AST_RWAKE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rwake_req_o && !bus_act_i) |=> rwake_req_o); // R7
  AST_RWAKE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rwake_req_o && !(sw_wake_i && clk_en_i && suspend_o)) |=> !rwake_req_o); // R7
endmodule

bind usb_susp_ctrl usb_susp_ctrl_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_act_i   (bus_act_i),
  .sw_wake_i   (sw_wake_i),
  .clk_en_i    (clk_en_i),
  .suspend_o   (suspend_o),
  .susp_irq_o  (susp_irq_o),
  .need_clk_o  (need_clk_o),
  .rwake_req_o (rwake_req_o)
);

// File: tb/test_usb_susp_ctrl.sv
module test_usb_susp_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SUSP_MS    = 3;
  localparam int CLK_OFF_MS = 2;
  localparam int S_LIM      = SUSP_MS + 1;
  localparam int O_LIM      = S_LIM + CLK_OFF_MS;

  logic clk_i = 0, rst_ni = 0;
  logic bus_act_i = 0, tick_1ms_i = 0, sw_wake_i = 0, clk_en_i = 0;
  logic suspend_o, susp_irq_o, need_clk_o, rwake_req_o;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  usb_susp_ctrl #(.SUSP_MS(SUSP_MS), .CLK_OFF_MS(CLK_OFF_MS)) i_usb_susp_ctrl (
    .clk_i, .rst_ni, .bus_act_i, .tick_1ms_i, .sw_wake_i, .clk_en_i,
    .suspend_o, .susp_irq_o, .need_clk_o, .rwake_req_o
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: idle time in ms, flags as bits
  int  m_idle;
  bit  m_susp, m_off, m_irq, m_rw;
  int  irq_seen;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_idle = 0; m_susp = 0; m_off = 0; m_irq = 0; m_rw = 0;
    end else begin
      bit wake_ok;
      int old_idle;
      wake_ok  = sw_wake_i && clk_en_i && m_susp;
      old_idle = m_idle;
      if (bus_act_i || wake_ok) begin
        m_idle = 0; m_susp = 0; m_off = 0; m_irq = 0;
      end else begin
        if (tick_1ms_i && m_idle < O_LIM) m_idle = m_idle + 1;
        m_irq = (old_idle >= S_LIM) && !m_susp;
        if (old_idle >= S_LIM) m_susp = 1;
        if (old_idle >= O_LIM) m_off = 1;
      end
      if (bus_act_i) m_rw = 0;
      else if (wake_ok) m_rw = 1;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      cycles++;
      check("R2 suspend_o", suspend_o, m_susp && !bus_act_i);
      check("R3 susp_irq_o", susp_irq_o, m_irq);
      check("R4 need_clk_o", need_clk_o, !m_off || bus_act_i);
      check("R7 rwake_req_o", rwake_req_o, m_rw);
      if (susp_irq_o) irq_seen++;
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic tick();
    tick_1ms_i = 1; step();
    tick_1ms_i = 0; step(3);
  endtask

  task automatic activity();
    bus_act_i = 1; step();
    bus_act_i = 0; step();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #3;
    check("R1 suspend_o", suspend_o, 0);
    check("R1 need_clk_o", need_clk_o, 1);
    check("R1 susp_irq_o", susp_irq_o, 0);
    check("R1 rwake_req_o", rwake_req_o, 0);
    step(2);
    rst_ni = 1;
    clk_en_i = 1;
    step(2);

    // R8: partial idle before activity is discarded
    repeat (S_LIM - 1) tick();
    activity();
    repeat (S_LIM - 1) tick();
    step(2);
    check("R8 no suspend after split idle", suspend_o, 0);
    // R2/R3: one more tick completes the window
    irq_seen = 0;
    tick();
    step(2);
    check("R2 suspend after threshold", suspend_o, 1);
    check("R3 one irq pulse", (irq_seen == 1), 1);
    check("R4 clock still needed", need_clk_o, 1);
    repeat (CLK_OFF_MS) tick();
    step(2);
    check("R4 clock released", need_clk_o, 0);
    check("R3 no retrigger", (irq_seen == 1), 1);

    // R5: combinational wake, checked before any edge
    @(negedge clk_i);
    bus_act_i = 1;
    #1;
    check("R5 comb suspend low", suspend_o, 0);
    check("R5 comb need_clk high", need_clk_o, 1);
    step();
    bus_act_i = 0;
    step();
    check("R5 registered clear suspend", suspend_o, 0);
    check("R5 registered clear need_clk", need_clk_o, 1);

    // R7: request ignored while not suspended
    sw_wake_i = 1; step(); sw_wake_i = 0; step();
    check("R7 ignored when awake", rwake_req_o, 0);

    // back into suspend, then request with clocks off
    repeat (S_LIM) tick();
    step(2);
    check("R2 suspend again", suspend_o, 1);
    clk_en_i = 0;
    sw_wake_i = 1; step(); sw_wake_i = 0; step();
    check("R7 ignored when clocks off", rwake_req_o, 0);
    check("R7 suspend kept", suspend_o, 1);

    // R6: accepted request
    clk_en_i = 1;
    sw_wake_i = 1; step(); sw_wake_i = 0;
    check("R6 rwake set", rwake_req_o, 1);
    check("R6 suspend cleared", suspend_o, 0);
    step(10);
    check("R7 rwake held", rwake_req_o, 1);
    activity();
    check("R7 rwake cleared by activity", rwake_req_o, 0);

    // mixed stimulus against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      bus_act_i  = (r < 3);
      tick_1ms_i = (r >= 50 && r < 75);
      sw_wake_i  = (r >= 90);
      clk_en_i   = ($urandom_range(0, 3) != 0);
      step();
    end
    bus_act_i = 0; tick_1ms_i = 0; sw_wake_i = 0;
    step(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule